// File: doc/BRIEF.md
# Reorder Buffer with Result Broadcast

This block keeps the in-flight instructions of a small out-of-order core in program order. Instructions enter at the tail through a valid/ready dispatch port. Each one receives a tag, which is the index of its slot. A rename table records, for every architectural register, the tag of the youngest in-flight instruction that will write that register. At dispatch each source operand is resolved in one of four ways: from the register file, from a producer that has already completed, from a result written back in the same cycle, or left waiting on a producer tag.

An execute port reads any slot directly by its index. It shows whether the slot is ready to issue, its opcode and operands, and its result once the slot is complete. A result written back to a tag completes that slot. The same result is broadcast to every slot, and each waiting operand whose producer tag matches captures the value. Completed instructions leave from the head in order through a valid/ready retire port. Each retirement writes its value to the register file.

An exception input, raised for the instruction at the head, flushes the whole buffer in one cycle. Back-pressure rules:
- `disp_ready` is low while the buffer is full or a flush is being applied. A dispatch happens only in a cycle where both `disp_valid` and `disp_ready` are high.
- `ret_valid` stays high, with the same head contents, until the consumer raises `ret_ready`.

Top module: `rob_core`

## Requirements
- R1: A dispatch is accepted when `disp_valid` and `disp_ready` are both high. The accepted instruction gets `disp_tag`, which equals the tail slot index. Tags are assigned consecutively and wrap from ROB_DEPTH-1 to 0.
- R2: While ROB_DEPTH instructions are held, `disp_ready` is low and a request on `disp_valid` is ignored. After one retirement, `disp_ready` rises and the next tag follows on from the last accepted one.
- R3: A source register with no pending producer takes its value from the register file and is ready at once. The register file resets to zero.
- R4: A source whose producer has not yet completed is not ready. When a result is written back to the producer's tag, every waiting operand with that tag captures the value and becomes ready.
- R5: A source whose producer has already completed, but has not yet retired, takes the producer's result at dispatch and is ready at once.
- R6: A result written back in the same cycle as a dependent dispatch is forwarded into the new slot, and that operand is ready.
- R7: For the slot selected by `exe_idx`, the execute port shows the slot's opcode and both operands. `exe_rdy` is high only when the slot is occupied, both operands are ready and the slot has not yet completed. `exe_done` and `exe_res` show the slot's completion state and its result.
- R8: `ret_valid` is high only when the head slot has completed. A younger slot that has completed waits behind an older slot that has not.
- R9: A retirement writes its result to the register file. It clears the register's rename mapping only if that mapping still holds the retiring tag. A mapping to a younger producer is kept.
- R10: `head_exc` empties the buffer, resets both pointers so the next tag is 0, and clears every rename mapping. In that cycle it blocks dispatch and retirement, so a retire requested in the same cycle writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Buffer can accept a dispatch |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | REG_W | Destination register |
| disp_src_a | input | REG_W | First source register |
| disp_src_b | input | REG_W | Second source register |
| disp_tag | output | TAG_W | Tag the dispatched instruction receives |
| exe_idx | input | TAG_W | Slot index read by the execute port |
| exe_rdy | output | 1 | Selected slot is ready to issue |
| exe_op | output | OP_W | Opcode of the selected slot |
| exe_a | output | DATA_W | First operand value of the selected slot |
| exe_b | output | DATA_W | Second operand value of the selected slot |
| exe_done | output | 1 | Selected slot has completed |
| exe_res | output | DATA_W | Result held by the selected slot |
| wb_valid | input | 1 | Result write-back strobe |
| wb_tag | input | TAG_W | Tag that produced the result |
| wb_value | input | DATA_W | Result value |
| ret_valid | output | 1 | Head slot has completed and may retire |
| ret_ready | input | 1 | Consumer accepts the retirement |
| ret_dst | output | REG_W | Destination register of the head slot |
| ret_value | output | DATA_W | Result of the head slot |
| head_exc | input | 1 | Exception at the head; flushes everything |

## Verification
The assertions check four invariants on every cycle:
- `disp_ready` agrees with a separately kept occupancy count.
- Each live rename mapping points at an occupied slot.
- A matching write-back always wakes a waiting operand in the following cycle.
- A flush always leaves an empty buffer whose next tag is 0.

Only the bench scenarios can show the values that flow through the buffer:
- which operand source dispatch picks, including the same-cycle forwarding case;
- in-order retirement behind an older incomplete slot;
- the conditional clearing of a rename mapping that a younger producer has replaced;
- a full buffer that ignores a request;
- a flush that swallows a retire requested in the same cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
  parameter int ROB_DEPTH = 8;   // power of two
  parameter int DATA_W    = 16;
  parameter int NUM_REGS  = 8;
  parameter int OP_W      = 4;

  localparam int TAG_W = $clog2(ROB_DEPTH);
  localparam int REG_W = $clog2(NUM_REGS);
  localparam int PTR_W = TAG_W + 1;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [OP_W-1:0]   op_t;

  typedef struct packed {
    logic  rdy;
    data_t val;
    tag_t  tag;
  } opnd_t;

  typedef struct packed {
    logic            vld;
    logic            done;
    data_t           res;
    reg_t            dst;
    op_t             op;
    opnd_t [1:0]     src;
  } slot_t;

  typedef struct packed {
    logic busy;
    tag_t tag;
  } map_t;
endpackage

// File: rtl/rob_regfile.sv
module rob_regfile
  import rob_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  reg_t  ra0,
  input  reg_t  ra1,
  output data_t rd0,
  output data_t rd1,
  input  logic  we,
  input  reg_t  wa,
  input  data_t wd
);
  data_t mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/rob_rename.sv
module rob_rename
  import rob_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  reg_t ra0,
  input  reg_t ra1,
  output map_t m0,
  output map_t m1,
  input  logic set_en,
  input  reg_t set_reg,
  input  tag_t set_tag,
  input  logic clr_en,
  input  reg_t clr_reg,
  input  tag_t clr_tag
);
  map_t tbl [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < NUM_REGS; i++) tbl[i] <= '0;
    end else begin
      // conditional clear first; a same-cycle set of the same register wins
      if (clr_en && tbl[clr_reg].busy && tbl[clr_reg].tag == clr_tag)
        tbl[clr_reg].busy <= 1'b0;
      if (set_en)
        tbl[set_reg] <= '{busy: 1'b1, tag: set_tag};
    end
  end

  assign m0 = tbl[ra0];
  assign m1 = tbl[ra1];

  // R9: a fresh mapping is visible on the read port one cycle later
  a_r9_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !flush && ra0 == set_reg && $stable(ra0)) |=>
      (flush || (m0.busy && m0.tag == $past(set_tag))));
endmodule

// File: rtl/rob_slot.sv
module rob_slot
  import rob_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  alloc,
  input  slot_t init,
  input  logic  clr,
  input  logic  wb_valid,
  input  tag_t  wb_tag,
  input  data_t wb_value,
  output slot_t q
);
  logic own_hit;
  assign own_hit = wb_valid && (wb_tag == tag_t'(IDX));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      q <= '0;
    end else if (alloc) begin
      q <= init;
    end else if (clr) begin
      q.vld  <= 1'b0;
      q.done <= 1'b0;
    end else if (q.vld) begin
      if (own_hit) begin
        q.done <= 1'b1;
        q.res  <= wb_value;
      end
      for (int k = 0; k < 2; k++) begin
        if (!q.src[k].rdy && wb_valid && q.src[k].tag == wb_tag) begin
          q.src[k].rdy <= 1'b1;
          q.src[k].val <= wb_value;
        end
      end
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_wake
    // R4: a broadcast to the awaited tag wakes the operand with that value
    a_r4_wakeup: assert property (@(posedge clk) disable iff (!rst_n)
      (q.vld && !q.src[k].rdy && wb_valid && q.src[k].tag == wb_tag &&
       !flush && !clr && !alloc) |=>
        (q.src[k].rdy && q.src[k].val == $past(wb_value)));
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  disp_valid,
  output logic  disp_ready,
  input  op_t   disp_op,
  input  reg_t  disp_dst,
  input  reg_t  disp_src_a,
  input  reg_t  disp_src_b,
  output tag_t  disp_tag,
  input  tag_t  exe_idx,
  output logic  exe_rdy,
  output op_t   exe_op,
  output data_t exe_a,
  output data_t exe_b,
  output logic  exe_done,
  output data_t exe_res,
  input  logic  wb_valid,
  input  tag_t  wb_tag,
  input  data_t wb_value,
  output logic  ret_valid,
  input  logic  ret_ready,
  output reg_t  ret_dst,
  output data_t ret_value,
  input  logic  head_exc
);
  logic [PTR_W-1:0] head_q, tail_q;
  tag_t  head_idx, tail_idx;
  logic  full, empty, disp_fire, ret_fire;
  slot_t slots [ROB_DEPTH];
  slot_t init, sel, hd;
  map_t  map_a, map_b;
  data_t rf_a, rf_b;

  assign head_idx = head_q[TAG_W-1:0];
  assign tail_idx = tail_q[TAG_W-1:0];
  assign empty    = (head_q == tail_q);
  assign full     = (head_q[TAG_W] != tail_q[TAG_W]) && (head_idx == tail_idx);

  assign disp_ready = !full && !head_exc;
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_tag   = tail_idx;

  assign hd        = slots[head_idx];
  assign ret_valid = !empty && hd.done;
  assign ret_dst   = hd.dst;
  assign ret_value = hd.res;
  assign ret_fire  = ret_valid && ret_ready && !head_exc;

  always_ff @(posedge clk) begin
    if (!rst_n || head_exc) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (disp_fire) tail_q <= tail_q + PTR_W'(1);
      if (ret_fire)  head_q <= head_q + PTR_W'(1);
    end
  end

  rob_rename u_ren (
    .clk(clk), .rst_n(rst_n), .flush(head_exc),
    .ra0(disp_src_a), .ra1(disp_src_b), .m0(map_a), .m1(map_b),
    .set_en(disp_fire), .set_reg(disp_dst), .set_tag(tail_idx),
    .clr_en(ret_fire), .clr_reg(hd.dst), .clr_tag(head_idx)
  );

  rob_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra0(disp_src_a), .ra1(disp_src_b), .rd0(rf_a), .rd1(rf_b),
    .we(ret_fire), .wa(hd.dst), .wd(hd.res)
  );

  // priority: no producer -> register file, completed producer, same-cycle result, wait
  function automatic opnd_t resolve(map_t m, data_t rfv, slot_t prod,
                                    logic fwd_en, tag_t fwd_tag, data_t fwd_val);
    opnd_t o;
    o.tag = m.tag;
    if (!m.busy) begin
      o.rdy = 1'b1; o.val = rfv;
    end else if (prod.done) begin
      o.rdy = 1'b1; o.val = prod.res;
    end else if (fwd_en && fwd_tag == m.tag) begin
      o.rdy = 1'b1; o.val = fwd_val;
    end else begin
      o.rdy = 1'b0; o.val = '0;
    end
    return o;
  endfunction

  always_comb begin
    init        = '0;
    init.vld    = 1'b1;
    init.dst    = disp_dst;
    init.op     = disp_op;
    init.src[0] = resolve(map_a, rf_a, slots[map_a.tag], wb_valid, wb_tag, wb_value);
    init.src[1] = resolve(map_b, rf_b, slots[map_b.tag], wb_valid, wb_tag, wb_value);
  end

  for (genvar i = 0; i < ROB_DEPTH; i++) begin : g_slot
    rob_slot #(.IDX(i)) u_slot (
      .clk(clk), .rst_n(rst_n), .flush(head_exc),
      .alloc(disp_fire && tail_idx == tag_t'(i)),
      .init(init),
      .clr(ret_fire && head_idx == tag_t'(i)),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
      .q(slots[i])
    );
  end

  assign sel      = slots[exe_idx];
  assign exe_rdy  = sel.vld && !sel.done && sel.src[0].rdy && sel.src[1].rdy;
  assign exe_op   = sel.op;
  assign exe_a    = sel.src[0].val;
  assign exe_b    = sel.src[1].val;
  assign exe_done = sel.done;
  assign exe_res  = sel.res;

  // occupancy kept apart from the pointers, for checking only
  logic [PTR_W-1:0] occ_q;
  always_ff @(posedge clk) begin
    if (!rst_n || head_exc) occ_q <= '0;
    else occ_q <= occ_q + PTR_W'(disp_fire) - PTR_W'(ret_fire);
  end

  // R2: dispatch is refused exactly when every slot is held
  a_r2_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    !head_exc |-> (disp_ready == (occ_q != PTR_W'(ROB_DEPTH))));

  // R1: an accepted dispatch occupies the slot named by its tag
  a_r1_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> slots[$past(tail_idx)].vld);

  // R9: a live rename mapping always names an occupied slot
  a_r9_map_live: assert property (@(posedge clk) disable iff (!rst_n)
    map_a.busy |-> slots[map_a.tag].vld);

  // R10: after a flush nothing can retire and the next tag is zero
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    head_exc |=> (!ret_valid && disp_ready && disp_tag == '0));
endmodule

// File: tb/sim_rob_core.sv
`timescale 1ns/1ps
module sim_rob_core;
  import rob_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, ret_ready = 0, wb_valid = 0, head_exc = 0;
  op_t  disp_op = '0;
  reg_t disp_dst = '0, disp_src_a = '0, disp_src_b = '0;
  tag_t exe_idx = '0, wb_tag = '0;
  data_t wb_value = '0;
  logic disp_ready, exe_rdy, exe_done, ret_valid;
  tag_t disp_tag;
  op_t  exe_op;
  data_t exe_a, exe_b, exe_res, ret_value;
  reg_t ret_dst;

  int checks = 0, fails = 0;
  data_t model [NUM_REGS];

  always #2 clk = ~clk;

  rob_core u0 (.*);

  // {dst[18:16], value[15:0]}: dispatch dst<=f(dst), complete, retire
  localparam logic [18:0] VEC [6] = '{
    {3'd1, 16'h1111}, {3'd2, 16'h2222}, {3'd1, 16'h3333},
    {3'd7, 16'hFFFF}, {3'd0, 16'h0A0A}, {3'd2, 16'h0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dsp(input int op, input int d, input int a, input int b, input int tag);
    disp_valid = 1; disp_op = op_t'(op); disp_dst = reg_t'(d);
    disp_src_a = reg_t'(a); disp_src_b = reg_t'(b);
    #1 chk("R1 ready", disp_ready, 1);
    chk("R1 tag", disp_tag, tag);
    @(negedge clk); disp_valid = 0;
  endtask

  task automatic wbk(input int tag, input int val);
    wb_valid = 1; wb_tag = tag_t'(tag); wb_value = data_t'(val);
    @(negedge clk); wb_valid = 0;
  endtask

  task automatic ret(input int d, input int val, input string req);
    ret_ready = 1;
    #1 chk(req, ret_valid, 1);
    chk(req, ret_dst, d);
    chk(req, ret_value, val);
    @(negedge clk); ret_ready = 0;
  endtask

  task automatic no_ret(input string req);
    #1 chk(req, ret_valid, 0);
    @(negedge clk);
  endtask

  task automatic peek_rdy(input int idx, input int rdy, input string req);
    exe_idx = tag_t'(idx);
    #1 chk(req, exe_rdy, rdy);
    @(negedge clk);
  endtask

  task automatic peek_ops(input int idx, input int op, input int a, input int b, input string req);
    exe_idx = tag_t'(idx);
    #1 chk(req, exe_rdy, 1);
    chk("R7 op", exe_op, op);
    chk(req, exe_a, a);
    chk(req, exe_b, b);
    @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < NUM_REGS; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R10 reset ready", disp_ready, 1);
    chk("R8 reset ret", ret_valid, 0);
    chk("R1 reset tag", disp_tag, 0);
    @(negedge clk);

    // table walk: R1 tags, R3 register file reads, R8/R9 retire writes
    for (int i = 0; i < 6; i++) begin
      int d;
      data_t v;
      d = int'(VEC[i][18:16]);
      v = VEC[i][15:0];
      dsp(i, d, d, 0, i);
      peek_ops(i, i, model[d], model[0], "R3 regfile operand");
      wbk(i, v);
      ret(d, v, "R9 retire");
      model[d] = v;
    end

    // R4 broadcast wakeup to several waiters
    dsp(8, 3, 1, 2, 6);
    peek_ops(6, 8, 16'h3333, 16'h0001, "R3 operands");
    dsp(9, 4, 3, 3, 7);
    peek_rdy(7, 0, "R4 waiting");
    dsp(10, 5, 0, 3, 0);             // tag wraps to 0
    wbk(6, 16'h0BEE);
    peek_ops(7, 9, 16'h0BEE, 16'h0BEE, "R4 wakeup both");
    peek_ops(0, 10, 16'h0A0A, 16'h0BEE, "R4 wakeup other slot");
    exe_idx = 3'd6;
    #1 chk("R7 done", exe_done, 1);
    chk("R7 res", exe_res, 16'h0BEE);
    chk("R7 not issuable", exe_rdy, 0);
    @(negedge clk);

    // R5 producer already complete
    dsp(11, 6, 3, 7, 1);
    peek_ops(1, 11, 16'h0BEE, 16'hFFFF, "R5 done producer");

    // R8 in-order retirement
    ret(3, 16'h0BEE, "R8 head");
    wbk(0, 16'h5555);
    no_ret("R8 younger waits");
    wbk(7, 16'h1234);
    ret(4, 16'h1234, "R8 order 1");
    ret(5, 16'h5555, "R8 order 2");
    no_ret("R8 incomplete head");
    wbk(1, 16'h6666);
    ret(6, 16'h6666, "R8 order 3");

    // R9 conditional rename clear
    dsp(0, 2, 0, 0, 2);
    dsp(0, 2, 0, 0, 3);
    wbk(2, 16'h0E0E);
    ret(2, 16'h0E0E, "R9 older writer");
    dsp(0, 1, 2, 0, 4);
    peek_rdy(4, 0, "R9 mapping kept");
    wbk(3, 16'h0F0F);
    peek_ops(4, 0, 16'h0F0F, 16'h0A0A, "R9 younger producer");
    ret(2, 16'h0F0F, "R9 younger writer");
    wbk(4, 16'h0101);
    ret(1, 16'h0101, "R9 retire");
    dsp(0, 7, 2, 1, 5);
    peek_ops(5, 0, 16'h0F0F, 16'h0101, "R9 mapping cleared");
    wbk(5, 16'h0202);
    ret(7, 16'h0202, "R9 retire");

    // R6 same-cycle forwarding
    dsp(0, 1, 0, 0, 6);
    disp_valid = 1; disp_op = 4'd5; disp_dst = 3'd3; disp_src_a = 3'd1; disp_src_b = 3'd1;
    wb_valid = 1; wb_tag = 3'd6; wb_value = 16'h7777;
    #1 chk("R6 ready", disp_ready, 1);
    chk("R6 tag", disp_tag, 7);
    @(negedge clk); disp_valid = 0; wb_valid = 0;
    peek_ops(7, 5, 16'h7777, 16'h7777, "R6 forwarded");
    ret(1, 16'h7777, "R6 retire");
    wbk(7, 16'h0303);
    ret(3, 16'h0303, "R6 retire");

    // R2 full buffer ignores a request
    for (int k = 0; k < ROB_DEPTH; k++) dsp(0, 0, 0, 0, k);
    disp_valid = 1; disp_dst = 3'd5;
    #1 chk("R2 full", disp_ready, 0);
    @(negedge clk); disp_valid = 0;
    wbk(0, 16'h0C0C);
    ret(0, 16'h0C0C, "R2 retire");
    #1 chk("R2 ready again", disp_ready, 1);
    chk("R2 tag unchanged", disp_tag, 0);
    @(negedge clk);

    // R10 flush beats retire and dispatch
    wbk(1, 16'hDEAD);
    head_exc = 1; ret_ready = 1; disp_valid = 1; disp_dst = 3'd3;
    #1 chk("R10 dispatch blocked", disp_ready, 0);
    @(negedge clk); head_exc = 0; ret_ready = 0; disp_valid = 0;
    #1 chk("R10 empty", ret_valid, 0);
    chk("R10 ready", disp_ready, 1);
    chk("R10 tag zero", disp_tag, 0);
    @(negedge clk);
    dsp(12, 4, 0, 5, 0);
    peek_ops(0, 12, 16'h0C0C, 16'h5555, "R10 rename cleared");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule